// File: doc/BRIEF.md
# Converter Register Front End

This block is the digital side of a 10-bit successive-approximation converter inside a microcontroller. It sits on an 8-bit CPU bus. Through that bus it exposes three registers: a control word, a read-only upper result byte, and a lower byte that mixes result bits with control fields. Toward the analog macro it drives four things: the power-on level, the channel code with a channel-valid flag, the amplifier-calibration level, and a single-cycle converter clock enable. The enable is divided down from the CPU clock.

The analog macro signals each finished conversion with a done strobe and a 10-bit result. While the converter is powered, each strobe captures the result and raises a completion flag. Software clears the flag by reading the upper result byte; there is no write that clears it. A two-bit rate code sets the enable rate to one half, the full rate, or one quarter of the CPU clock. The rate code is built from a slow bit in the lower register and a speed bit in the control word.

Register addresses: control word at 0, upper result byte at 1, lower byte at 2. All reads are combinational from the current register state.

Top module: `adc_regif`

## Requirements
- R1: After reset, the control word and the lower byte read 0x00, the upper byte reads 0x00, and adcPowerOn, ampCalEn and adcClkEn are low.
- R2: Control word (address 0): bit 6 is the speed bit, bit 5 is converter-on and bits 2:0 are the channel. These bits are written and read back. Bit 7 is the completion flag and ignores writes. Bits 4:3 ignore writes and read 0.
- R3: Lower byte (address 2): bit 4 is amplifier calibration and bit 3 is the slow bit. Both are written and read back. Bits 1:0 return result bits 1:0 and ignore writes. Bits 7:5 and bit 2 always read 0.
- R4: The upper byte (address 1) returns result bits 9:2. Writes to it change nothing.
- R5: A done strobe while converter-on is 1 captures all 10 result bits in that cycle and sets the completion flag (control bit 7).
- R6: A read of the upper byte clears the completion flag after that cycle. If a done strobe arrives in the same cycle, the flag stays set and the new result is captured.
- R7: A done strobe overwrites the held result even while the completion flag is still set.
- R8: While converter-on is 0, done strobes are ignored (result and flag unchanged) and adcClkEn stays low.
- R9: With the converter on, the rate code {slow, speed} gives single-cycle adcClkEn pulses: every cycle for 01, every 2nd cycle for 00, every 4th cycle for 10 or 11.
- R10: A write that changes converter-on, speed or slow restarts the divider. With the converter on, the first adcClkEn pulse comes N cycles after the write edge, where N is the division ratio.
- R11: adcChannel follows channel bits 2:0. adcChanValid is 1 for codes 0 to 6 and 0 for code 7, which is still stored.
- R12: adcPowerOn follows control bit 5 and ampCalEn follows lower-byte bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| convResult | input | 10 | Result from analog macro |
| convDone | input | 1 | Conversion done strobe |
| adcClkEn | output | 1 | Converter clock enable pulse |
| adcPowerOn | output | 1 | Converter and amplifier power |
| adcChannel | output | 3 | Input channel code |
| adcChanValid | output | 1 | Channel code is a supported input |
| ampCalEn | output | 1 | Ties amplifier input to 0 V |

## Verification
The hardest case to reach is a done strobe that lands in the same cycle as the CPU's read of the upper byte. Here the flag-clearing side effect must lose to the new completion, and the read must still return the old byte. The stimulus asserts the read and the done strobe on the same falling edge. It samples the read data before the rising edge, then reads the control word and the upper byte again. The divider-restart timing is also hard to see from outside. The bench counts rising edges from the configuring write to the first enable pulse for each ratio.

// File: rtl/adc_regif_pkg.sv
package adc_regif_pkg;

  // bit positions decoded by software and the control path
  localparam int CTL_EOC_BIT   = 7;
  localparam int CTL_SPEED_BIT = 6;
  localparam int CTL_ON_BIT    = 5;
  localparam int LOW_CAL_BIT   = 4;
  localparam int LOW_SLOW_BIT  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtl;
    logic wrLow;
    logic rdHigh;
    logic latchRes;
    logic restartDiv;
  } ctlStrobe_t;

endpackage

// File: rtl/adc_regif_ctrl.sv
module adc_regif_ctrl
  import adc_regif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int ADDR_CTL  = 0,
  parameter int ADDR_HIGH = 1,
  parameter int ADDR_LOW  = 2
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              convDone,
  input  logic              curOn,
  input  logic              curSpeed,
  input  logic              curSlow,
  output ctlStrobe_t        st
);

  logic hitCtl, hitHigh, hitLow;
  logic onChange, speedChange, slowChange;

  always_comb begin
    hitCtl  = busSel && (busAddr == ADDR_W'(ADDR_CTL));
    hitHigh = busSel && (busAddr == ADDR_W'(ADDR_HIGH));
    hitLow  = busSel && (busAddr == ADDR_W'(ADDR_LOW));

    st.wrCtl    = hitCtl && busWr;
    st.wrLow    = hitLow && busWr;
    st.rdHigh   = hitHigh && busRd;
    st.latchRes = convDone && curOn;

    onChange    = st.wrCtl && (busWdata[CTL_ON_BIT] != curOn);
    speedChange = st.wrCtl && (busWdata[CTL_SPEED_BIT] != curSpeed);
    slowChange  = st.wrLow && (busWdata[LOW_SLOW_BIT] != curSlow);
    st.restartDiv = onChange || speedChange || slowChange;
  end

endmodule

// File: rtl/adc_regif_prescale.sv
module adc_regif_prescale #(
  parameter int MAX_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] selCode,
  input  logic       restart,
  output logic       clkEn
);

  localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
  localparam int MID_DIV = (MAX_DIV > 1) ? MAX_DIV / 2 : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    case (selCode)
      2'b01:   lastCnt = '0;
      2'b00:   lastCnt = CNT_W'(MID_DIV - 1);
      default: lastCnt = CNT_W'(MAX_DIV - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      clkEn <= 1'b0;
    end else if (restart || !enable) begin
      cnt   <= '0;
      clkEn <= 1'b0;
    end else begin
      clkEn <= (cnt == lastCnt);
      cnt   <= (cnt == lastCnt) ? '0 : cnt + 1'b1;
    end
  end

  // R8
  no_en_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clkEn);

  // R9
  quarter_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn && selCode[1]) |=> !clkEn);

  // R10
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !clkEn);

endmodule

// File: rtl/adc_regif_dp.sv
module adc_regif_dp
  import adc_regif_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RES_W     = 10,
  parameter int ADDR_W    = 2,
  parameter int CHAN_W    = 3,
  parameter int NUM_CHAN  = 7,
  parameter int ADDR_CTL  = 0,
  parameter int ADDR_HIGH = 1,
  parameter int ADDR_LOW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [RES_W-1:0]  convResult,
  output logic [DATA_W-1:0] busRdata,
  output logic              cfgOn,
  output logic              cfgSpeed,
  output logic              cfgSlow,
  output logic              ampCal,
  output logic [CHAN_W-1:0] chanSel,
  output logic              chanValid
);

  localparam int LOW_RES_W = RES_W - DATA_W;

  logic              eocQ;
  logic              speedQ;
  logic              onQ;
  logic [CHAN_W-1:0] chanQ;
  logic              calQ;
  logic              slowQ;
  logic [RES_W-1:0]  resultQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eocQ    <= 1'b0;
      speedQ  <= 1'b0;
      onQ     <= 1'b0;
      chanQ   <= '0;
      calQ    <= 1'b0;
      slowQ   <= 1'b0;
      resultQ <= '0;
    end else begin
      if (st.wrCtl) begin
        speedQ <= busWdata[CTL_SPEED_BIT];
        onQ    <= busWdata[CTL_ON_BIT];
        chanQ  <= busWdata[CHAN_W-1:0];
      end
      if (st.wrLow) begin
        calQ  <= busWdata[LOW_CAL_BIT];
        slowQ <= busWdata[LOW_SLOW_BIT];
      end
      if (st.latchRes) begin
        resultQ <= convResult;
      end
      if (st.latchRes) begin
        eocQ <= 1'b1;
      end else if (st.rdHigh) begin
        eocQ <= 1'b0;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(ADDR_CTL)) begin
      busRdata[CTL_EOC_BIT]   = eocQ;
      busRdata[CTL_SPEED_BIT] = speedQ;
      busRdata[CTL_ON_BIT]    = onQ;
      busRdata[CHAN_W-1:0]    = chanQ;
    end else if (busAddr == ADDR_W'(ADDR_HIGH)) begin
      busRdata = resultQ[RES_W-1 -: DATA_W];
    end else if (busAddr == ADDR_W'(ADDR_LOW)) begin
      busRdata[LOW_CAL_BIT]     = calQ;
      busRdata[LOW_SLOW_BIT]    = slowQ;
      busRdata[LOW_RES_W-1:0]   = resultQ[LOW_RES_W-1:0];
    end
  end

  always_comb begin
    cfgOn     = onQ;
    cfgSpeed  = speedQ;
    cfgSlow   = slowQ;
    ampCal    = calQ;
    chanSel   = chanQ;
    chanValid = ({1'b0, chanQ} < (CHAN_W + 1)'(NUM_CHAN));
  end

  // R5
  eoc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.latchRes |=> (eocQ && resultQ == $past(convResult)));

  // R6
  eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.rdHigh && !st.latchRes) |=> !eocQ);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st.latchRes |=> $stable(resultQ));

  // R3
  low_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr == ADDR_W'(ADDR_LOW)) |-> (busRdata[7:5] == 3'b000 && !busRdata[2]));

endmodule

// File: rtl/adc_regif.sv
module adc_regif
  import adc_regif_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RES_W    = 10,
  parameter int ADDR_W   = 2,
  parameter int CHAN_W   = 3,
  parameter int NUM_CHAN = 7,
  parameter int MAX_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [RES_W-1:0]  convResult,
  input  logic              convDone,
  output logic              adcClkEn,
  output logic              adcPowerOn,
  output logic [CHAN_W-1:0] adcChannel,
  output logic              adcChanValid,
  output logic              ampCalEn
);

  localparam int ADDR_CTL  = 0;
  localparam int ADDR_HIGH = 1;
  localparam int ADDR_LOW  = 2;

  ctlStrobe_t st;
  logic cfgOn, cfgSpeed, cfgSlow;

  adc_regif_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .ADDR_CTL(ADDR_CTL), .ADDR_HIGH(ADDR_HIGH), .ADDR_LOW(ADDR_LOW)
  ) uCtrl (
    .busSel(busSel), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .convDone(convDone),
    .curOn(cfgOn), .curSpeed(cfgSpeed), .curSlow(cfgSlow), .st(st)
  );

  adc_regif_dp #(
    .DATA_W(DATA_W), .RES_W(RES_W), .ADDR_W(ADDR_W), .CHAN_W(CHAN_W),
    .NUM_CHAN(NUM_CHAN),
    .ADDR_CTL(ADDR_CTL), .ADDR_HIGH(ADDR_HIGH), .ADDR_LOW(ADDR_LOW)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .st(st), .busAddr(busAddr),
    .busWdata(busWdata), .convResult(convResult), .busRdata(busRdata),
    .cfgOn(cfgOn), .cfgSpeed(cfgSpeed), .cfgSlow(cfgSlow),
    .ampCal(ampCalEn), .chanSel(adcChannel), .chanValid(adcChanValid)
  );

  adc_regif_prescale #(.MAX_DIV(MAX_DIV)) uDiv (
    .clk(clk), .rst_n(rst_n), .enable(cfgOn),
    .selCode({cfgSlow, cfgSpeed}), .restart(st.restartDiv), .clkEn(adcClkEn)
  );

  assign adcPowerOn = cfgOn;

endmodule

// File: tb/adc_regif_test.sv
module adc_regif_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [9:0] convResult = '0;
  logic       convDone = 1'b0;
  logic       adcClkEn, adcPowerOn, adcChanValid, ampCalEn;
  logic [2:0] adcChannel;

  int checks = 0;
  int errors = 0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  adc_regif uut (
    .clk(clk), .rst_n(rst_n), .busSel(busSel), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .convResult(convResult), .convDone(convDone), .adcClkEn(adcClkEn),
    .adcPowerOn(adcPowerOn), .adcChannel(adcChannel),
    .adcChanValid(adcChanValid), .ampCalEn(ampCalEn)
  );

  // {addr, write data, expected read-back}
  localparam int NVEC = 11;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'hFF, 8'h67}, {2'd0, 8'h98, 8'h00}, {2'd0, 8'h45, 8'h45},
    {2'd0, 8'h26, 8'h26}, {2'd2, 8'hFF, 8'h18}, {2'd2, 8'hE7, 8'h00},
    {2'd2, 8'h10, 8'h10}, {2'd2, 8'h08, 8'h08}, {2'd1, 8'hAA, 8'h00},
    {2'd2, 8'h00, 8'h00}, {2'd0, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1; busRd = 1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 0; busRd = 0;
  endtask

  task automatic pulseDone(input logic [9:0] r);
    @(negedge clk);
    convDone = 1; convResult = r;
    @(negedge clk);
    convDone = 0;
  endtask

  task automatic countEn(output int n);
    n = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (adcClkEn) n++;
    end
  endtask

  // write, then count rising edges until the first enable pulse
  task automatic restartDelay(input logic [1:0] a, input logic [7:0] d, output int n);
    busWrite(a, d);
    n = adcClkEn ? 0 : -1;
    for (int i = 1; i <= 8 && n < 0; i++) begin
      @(negedge clk);
      if (adcClkEn) n = i;
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    busRead(2'd0, rd); chk("R1 ctl", rd, 8'h00);
    busRead(2'd2, rd); chk("R1 low", rd, 8'h00);
    busRead(2'd1, rd); chk("R1 high", rd, 8'h00);
    chk("R1 outs", {adcPowerOn, ampCalEn, adcClkEn}, 0);

    // R2 R3 R4 register table
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VEC[i][17:16], VEC[i][15:8]);
      busRead(VEC[i][17:16], rd);
      chk(VEC[i][17:16] == 2'd0 ? "R2 table" :
          VEC[i][17:16] == 2'd1 ? "R4 table" : "R3 table", rd, VEC[i][7:0]);
    end

    // R11 R12 on, channel 3
    busWrite(2'd0, 8'h23);
    chk("R12 power", adcPowerOn, 1);
    chk("R11 chan3", {adcChannel, adcChanValid}, {3'd3, 1'b1});

    // R5 capture and flag
    pulseDone(10'h2D6);
    busRead(2'd0, rd); chk("R5 flag", rd, 8'hA3);
    busRead(2'd2, rd); chk("R5 low", rd, 8'h02);
    busRead(2'd1, rd); chk("R5 high", rd, 8'hB5);
    busRead(2'd0, rd); chk("R6 cleared", rd, 8'h23);

    // R7 overwrite while flag set
    pulseDone(10'h155);
    pulseDone(10'h3FF);
    busRead(2'd0, rd); chk("R7 flag", rd, 8'hA3);
    busRead(2'd2, rd); chk("R7 low", rd, 8'h03);
    busRead(2'd1, rd); chk("R7 high", rd, 8'hFF);

    // R6 done in same cycle as upper-byte read
    pulseDone(10'h3FC);
    @(negedge clk);
    busSel = 1; busRd = 1; busAddr = 2'd1; convDone = 1; convResult = 10'h001;
    #1 rd = busRdata;
    @(negedge clk);
    busSel = 0; busRd = 0; convDone = 0;
    chk("R6 same-cycle old data", rd, 8'hFF);
    busRead(2'd0, rd); chk("R6 same-cycle flag kept", rd, 8'hA3);
    busRead(2'd2, rd); chk("R6 same-cycle low", rd, 8'h01);
    busRead(2'd1, rd); chk("R6 same-cycle high", rd, 8'h00);
    busRead(2'd0, rd); chk("R6 flag cleared", rd, 8'h23);

    // R8 converter off
    busWrite(2'd0, 8'h03);
    pulseDone(10'h3FF);
    busRead(2'd0, rd); chk("R8 no flag", rd, 8'h03);
    busRead(2'd1, rd); chk("R8 result held", rd, 8'h00);
    countEn(n); chk("R8 no enable", n, 0);
    chk("R12 power off", adcPowerOn, 0);

    // R11 channel validity
    busWrite(2'd0, 8'h27);
    chk("R11 chan7", {adcChannel, adcChanValid}, {3'd7, 1'b0});
    busRead(2'd0, rd); chk("R11 chan7 stored", rd, 8'h27);
    busWrite(2'd0, 8'h26);
    chk("R11 chan6", {adcChannel, adcChanValid}, {3'd6, 1'b1});

    // R12 calibration
    busWrite(2'd2, 8'h10); chk("R12 cal on", ampCalEn, 1);
    busWrite(2'd2, 8'h00); chk("R12 cal off", ampCalEn, 0);

    // R9 rates (on, code 00 at this point)
    countEn(n); chk("R9 div2", n, 8);
    busWrite(2'd0, 8'h60); countEn(n); chk("R9 div1", n, 16);
    busWrite(2'd2, 8'h08); countEn(n); chk("R9 div4 code11", n, 4);
    busWrite(2'd0, 8'h20); countEn(n); chk("R9 div4 code10", n, 4);

    // R10 divider restart
    busWrite(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    restartDelay(2'd2, 8'h08, n); chk("R10 to div4", n, 4);
    restartDelay(2'd0, 8'h60, n); chk("R10 speed change div4", n, 4);
    restartDelay(2'd2, 8'h00, n); chk("R10 to div1", n, 1);
    busWrite(2'd0, 8'h00);
    restartDelay(2'd0, 8'h20, n); chk("R10 power-on div2", n, 2);

    finishRun();
  end

endmodule